// File: doc/BRIEF.md
# Multiplexed Four-Digit Decade Display

This block drives a seven-segment display of several digits (four by default) whose segment lines are shared by every digit. Each digit owns a decimal counter that starts at zero when reset is released and advances by one every second, returning from 9 to 0. A scan pointer selects one digit at a time in a fixed rotating order. For each digit it holds one anode line low for a dwell time derived from the clock frequency, and it drives the shared cathodes with that digit's pattern in the same cycle.

A debug override input replaces the displayed value of every digit with a nibble taken from a debug bus. The counters keep running underneath, so removing the override shows the current count straight away. The clock frequency, the per-digit dwell time and the digit count are parameters. Elaboration rejects any setting whose full refresh frame falls outside 1 to 16 ms.

Top module: `decscan_display`

## Requirements
- R1: While reset is held and right after it, digit 0 is selected (`an_n` = 4'b1110), the cathodes show the glyph for 0 and the decimal point is dark.
- R2: Exactly one bit of `an_n` is low in every cycle, and both anode and cathode outputs are active-low.
- R3: Digits are selected in the rotating order 0, 1, 2, 3, 0, … and each stays selected for exactly DWELL cycles. The selected digit after n clock edges since reset is (n / DWELL) mod 4.
- R4: DWELL = (CLK_HZ/1000)·DWELL_US/1000 cycles. Elaboration fails unless the frame time N_DIGITS·DWELL_US lies between 1000 and 16000 µs.
- R5: Every digit counter advances once every CLK_HZ cycles, so after n edges each digit holds (n / CLK_HZ) mod 10.
- R6: A digit counter holding 9 returns to 0 on its next advance and never holds a value above 9.
- R7: Bit k of `seg_n` drives segment a+k (bit 0 = a … bit 6 = g), and a lit segment is 0. The active-high gfedcba patterns for 0–9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R8: The anode and cathode outputs change on the same clock edge. When a one-second advance and a digit step fall on the same edge, the outputs after that edge show the newly selected digit with its new count.
- R9: While `dbg_en` is high, the selected digit k shows `dbg_digits[4k+3:4k]` in place of its count.
- R10: An override nibble above 9 blanks the selected digit (`seg_n` = 7'h7F).
- R11: The override has no effect on the counters. After `dbg_en` falls, the display shows the count that R5 gives for the elapsed time.
- R12: `dp_n` stays high (dark) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Selects the override nibbles in place of the counts |
| dbg_digits | input | 4·N_DIGITS | Override value, nibble k for digit k |
| an_n | output | N_DIGITS | Digit anode selects, active-low |
| seg_n | output | 7 | Shared segment cathodes a–g, active-low |
| dp_n | output | 1 | Decimal-point cathode, held dark |

## Verification
The one-second advance and the digit step are independent dividers, but both land on the same edge whenever the elapsed cycle count is a multiple of the second length. With a scaled clock of 8000 Hz and a 1 ms dwell, that first happens on edge 8000, where digit 3 hands over to digit 0. The bench checks the outputs every cycle around that edge. Just before it, digit 3 must show 0. Just after it, digit 0 must show 1, with no cycle where the old count appears on the new anode. The same coincidence is checked again at edge 80000, where every counter goes from 9 to 0.

// File: rtl/decscan_pkg.sv
package decscan_pkg;

   localparam int unsigned BCD_W = 4;
   localparam int unsigned SEG_W = 7;
   localparam int unsigned BCD_MAX = 9;

   typedef logic [BCD_W-1:0] bcd_t;
   typedef logic [SEG_W-1:0] seg_t;

   // active-high segments, bit 0 = a ... bit 6 = g; non-decimal values dark
   function automatic seg_t glyph(input bcd_t v);
      seg_t s;
      case (v)
         4'd0:    s = 7'h3F;
         4'd1:    s = 7'h06;
         4'd2:    s = 7'h5B;
         4'd3:    s = 7'h4F;
         4'd4:    s = 7'h66;
         4'd5:    s = 7'h6D;
         4'd6:    s = 7'h7D;
         4'd7:    s = 7'h07;
         4'd8:    s = 7'h7F;
         4'd9:    s = 7'h6F;
         default: s = 7'h00;
      endcase
      return s;
   endfunction

   function automatic bcd_t bcd_step(input bcd_t v);
      return (v >= bcd_t'(BCD_MAX)) ? bcd_t'(0) : bcd_t'(v + bcd_t'(1));
   endfunction

endpackage

// File: rtl/decscan_pulse_div.sv
module decscan_pulse_div #(
   parameter int unsigned PERIOD = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("decscan_pulse_div: PERIOD must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/decscan_digit_bank.sv
module decscan_digit_bank
   import decscan_pkg::*;
#(
   parameter int unsigned N_DIGITS = 4,
   localparam int unsigned BUS_W = N_DIGITS * BCD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [BUS_W-1:0] cur,
   output logic [BUS_W-1:0] nxt
);

   generate
      for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
         bcd_t val_q;
         bcd_t val_d;

         assign val_d = advance ? bcd_step(val_q) : val_q;
         assign nxt[g*BCD_W +: BCD_W] = val_d;
         assign cur[g*BCD_W +: BCD_W] = val_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q <= '0;
            end else begin
               val_q <= val_d;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/decscan_scan_ptr.sv
module decscan_scan_ptr #(
   parameter int unsigned N_DIGITS = 4,
   parameter int unsigned DWELL    = 100000,
   parameter int unsigned IDX_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [IDX_W-1:0] idx_next
);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_DIGITS - 1);

   logic             step;
   logic [IDX_W-1:0] idx_q;

   decscan_pulse_div #(
      .PERIOD(DWELL)
   ) u_dwell (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (step)
   );

   always_comb begin
      idx_next = idx_q;
      if (step) begin
         idx_next = (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else begin
         idx_q <= idx_next;
      end
   end

endmodule

// File: rtl/decscan_out_stage.sv
module decscan_out_stage
   import decscan_pkg::*;
#(
   parameter int unsigned N_DIGITS = 4,
   parameter int unsigned IDX_W    = 2,
   localparam int unsigned BUS_W   = N_DIGITS * BCD_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    idx_next,
   input  logic [BUS_W-1:0]    digit_nxt,
   input  logic                dbg_en,
   input  logic [BUS_W-1:0]    dbg_digits,
   output logic [N_DIGITS-1:0] an_n,
   output seg_t                seg_n
);
   localparam logic [N_DIGITS-1:0] ONE = N_DIGITS'(1);

   bcd_t                sel_val;
   logic [N_DIGITS-1:0] an_d;
   seg_t                seg_d;

   always_comb begin
      if (dbg_en) begin
         sel_val = dbg_digits[idx_next*BCD_W +: BCD_W];
      end else begin
         sel_val = digit_nxt[idx_next*BCD_W +: BCD_W];
      end
      an_d  = ~(ONE << idx_next);
      seg_d = ~glyph(sel_val);
   end

   // anode and cathode share one register stage so they move on one edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         an_n  <= ~ONE;
         seg_n <= ~glyph(bcd_t'(0));
      end else begin
         an_n  <= an_d;
         seg_n <= seg_d;
      end
   end

endmodule

// File: rtl/decscan_display.sv
module decscan_display
   import decscan_pkg::*;
#(
   parameter int unsigned N_DIGITS = 4,
   parameter int unsigned CLK_HZ   = 100_000_000,
   parameter int unsigned DWELL_US = 1000,
   localparam int unsigned BUS_W   = N_DIGITS * BCD_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dbg_en,
   input  logic [BUS_W-1:0]    dbg_digits,
   output logic [N_DIGITS-1:0] an_n,
   output logic [SEG_W-1:0]    seg_n,
   output logic                dp_n
);
   localparam int unsigned SEC_CYCLES   = CLK_HZ;
   localparam int unsigned DWELL_CYCLES = (CLK_HZ / 1000) * DWELL_US / 1000;
   localparam int unsigned FRAME_US     = N_DIGITS * DWELL_US;
   localparam int unsigned IDX_W        = (N_DIGITS > 2) ? $clog2(N_DIGITS) : 1;

   generate
      if (N_DIGITS < 2) begin : g_bad_digits
         $error("decscan_display: N_DIGITS must be at least 2");
      end
      if ((CLK_HZ % 1000) != 0) begin : g_bad_clk
         $error("decscan_display: CLK_HZ must be a multiple of 1000");
      end
      if (DWELL_CYCLES < 2) begin : g_bad_dwell
         $error("decscan_display: dwell must span at least two cycles");
      end
      if (FRAME_US < 1000 || FRAME_US > 16000) begin : g_bad_frame
         $error("decscan_display: refresh frame outside 1..16 ms");
      end
   endgenerate

   logic             sec_tick;
   logic [BUS_W-1:0] digit_cur;
   logic [BUS_W-1:0] digit_nxt;
   logic [IDX_W-1:0] idx_next;

   decscan_pulse_div #(
      .PERIOD(SEC_CYCLES)
   ) u_second (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (sec_tick)
   );

   decscan_digit_bank #(
      .N_DIGITS(N_DIGITS)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .advance(sec_tick),
      .cur    (digit_cur),
      .nxt    (digit_nxt)
   );

   decscan_scan_ptr #(
      .N_DIGITS(N_DIGITS),
      .DWELL   (DWELL_CYCLES),
      .IDX_W   (IDX_W)
   ) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_next(idx_next)
   );

   decscan_out_stage #(
      .N_DIGITS(N_DIGITS),
      .IDX_W   (IDX_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_next  (idx_next),
      .digit_nxt (digit_nxt),
      .dbg_en    (dbg_en),
      .dbg_digits(dbg_digits),
      .an_n      (an_n),
      .seg_n     (seg_n)
   );

   assign dp_n = 1'b1;

endmodule

// File: rtl/decscan_display_chk.sv
module decscan_display_chk #(
   parameter int unsigned N_DIGITS = 4,
   localparam int unsigned BUS_W   = N_DIGITS * 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_DIGITS-1:0] an_n,
   input logic [6:0]          seg_n,
   input logic                dbg_en,
   input logic                sec_tick,
   input logic [BUS_W-1:0]    digit_cur
);

   p_one_anode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~an_n) == 1);

   p_anode_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (an_n != $past(an_n)) |->
         (an_n == {$past(an_n[N_DIGITS-2:0]), $past(an_n[N_DIGITS-1])}));

   // R8: cathodes move only with a digit step, a second advance or the override
   p_seg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((an_n == $past(an_n)) && !$past(sec_tick) && !$past(dbg_en) && !$past(dbg_en, 2))
         |-> $stable(seg_n));

   generate
      for (genvar g = 0; g < N_DIGITS; g++) begin : g_dig_chk
         p_digit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            digit_cur[g*4 +: 4] <= 4'd9);

         p_digit_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (sec_tick && (digit_cur[g*4 +: 4] == 4'd9)) |=> (digit_cur[g*4 +: 4] == 4'd0));
      end
   endgenerate

endmodule

bind decscan_display decscan_display_chk #(
   .N_DIGITS(N_DIGITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .an_n     (an_n),
   .seg_n    (seg_n),
   .dbg_en   (dbg_en),
   .sec_tick (sec_tick),
   .digit_cur(digit_cur)
);

// File: tb/decscan_display_bench.sv
module decscan_display_bench;
   localparam int ND       = 4;
   localparam int CLK_HZ   = 8000;
   localparam int DWELL_US = 1000;
   localparam int DWELL    = 8;     // 8000 Hz * 1 ms
   localparam int SEC      = 8000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dbg_en = 1'b0;
   logic [15:0]   dbg_digits = '0;
   logic [ND-1:0] an_n;
   logic [6:0]    seg_n;
   logic          dp_n;

   int          n;
   logic        m_en;
   logic [15:0] m_dig;
   int          checks = 0;
   int          errors = 0;

   always #4 clk = ~clk;

   decscan_display #(
      .N_DIGITS(ND),
      .CLK_HZ  (CLK_HZ),
      .DWELL_US(DWELL_US)
   ) u_decscan_display (
      .clk       (clk),
      .rst_n     (rst_n),
      .dbg_en    (dbg_en),
      .dbg_digits(dbg_digits),
      .an_n      (an_n),
      .seg_n     (seg_n),
      .dp_n      (dp_n)
   );

   // edge counter and captured override: the bench's own timeline
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n     <= 0;
         m_en  <= 1'b0;
         m_dig <= '0;
      end else begin
         n     <= n + 1;
         m_en  <= dbg_en;
         m_dig <= dbg_digits;
      end
   end

   function automatic logic [6:0] ref_glyph(input int v);
      case (v)
         0: return 7'h3F;
         1: return 7'h06;
         2: return 7'h5B;
         3: return 7'h4F;
         4: return 7'h66;
         5: return 7'h6D;
         6: return 7'h7D;
         7: return 7'h07;
         8: return 7'h7F;
         9: return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction

   task automatic check_out(input string req);
      int idx;
      int val;
      logic [ND-1:0] exp_an;
      logic [6:0] exp_seg;
      idx = (n / DWELL) % ND;
      val = m_en ? int'(m_dig[idx*4 +: 4]) : (n / SEC) % 10;
      exp_an  = ~(4'b0001 << idx);
      exp_seg = ~ref_glyph(val);
      checks++;
      if (an_n !== exp_an || seg_n !== exp_seg) begin
         errors++;
         $display("FAIL %s n=%0d actual an_n=%b seg_n=%h expected an_n=%b seg_n=%h",
                  req, n, an_n, seg_n, exp_an, exp_seg);
      end
   endtask

   task automatic check_misc();
      checks++;
      if ($countones(~an_n) != 1) begin
         errors++;
         $display("FAIL R2 n=%0d actual an_n=%b expected exactly one low", n, an_n);
      end
      checks++;
      if (dp_n !== 1'b1) begin
         errors++;
         $display("FAIL R12 n=%0d actual dp_n=%b expected 1", n, dp_n);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_to(input int target);
      while (n < target) step();
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check_out("R1");
      checks++;
      if (an_n !== 4'b1110 || seg_n !== 7'h40 || dp_n !== 1'b1) begin
         errors++;
         $display("FAIL R1 actual an_n=%b seg_n=%h dp_n=%b expected 1110 40 1",
                  an_n, seg_n, dp_n);
      end
      rst_n = 1'b1;
      step();
      check_out("R1");
   endtask

   task automatic t_scan();
      for (int i = 0; i < 4 * ND * DWELL; i++) begin
         check_out("R3");
         check_out("R4");
         check_out("R7");
         check_misc();
         step();
      end
   endtask

   task automatic t_coincide();
      run_to(SEC - 3 * DWELL);
      while (n < SEC + 2 * DWELL) begin
         check_out((n == SEC || n == SEC - 1) ? "R8" : "R5");
         check_misc();
         step();
      end
   endtask

   task automatic t_debug(input logic [15:0] pat);
      dbg_en     = 1'b1;
      dbg_digits = pat;
      step();
      for (int i = 0; i < 2 * ND * DWELL; i++) begin
         check_out("R9");
         check_out("R10");
         step();
      end
   endtask

   task automatic t_release();
      dbg_en = 1'b0;
      step();
      for (int i = 0; i < ND * DWELL; i++) begin
         check_out("R11");
         step();
      end
   endtask

   task automatic t_wrap();
      run_to(10 * SEC - 2 * DWELL);
      while (n < 10 * SEC + 2 * DWELL) begin
         check_out("R6");
         check_misc();
         step();
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired at n=%0d expected completion", n);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_scan();
      t_coincide();
      run_to(3 * SEC + 5);
      t_debug(16'h9A31);
      t_debug(16'h07F2);
      t_release();
      t_wrap();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule